// File: doc/BRIEF.md
# Master-to-Slave Timer Start Trigger

This block links one master timer to a group of slave timers so that the slaves start counting on an event from the master instead of on a software enable alone. On the master side, a 3-bit selector picks which master event drives the shared trigger output. The choices are the counter-reset event, the counter-enable level, the update (overflow) pulse, or one of four compare reference levels. The chosen value is registered in the master clock domain and leaves the block as `mst_trgo`.

Each slave has its own 3-bit trigger-select field and a 2-bit mode field. Code 0 of the select field picks the master trigger output. Codes 1 to 7 pick the other internal trigger inputs. All trigger inputs are brought into the slave clock domain through two-flop synchronizers, which are shared by every slave. Each slave then runs a small state machine that detects a rising edge on its selected, synchronized input.

The states are IDLE (not armed), ARMED (trigger mode, waiting) and RUN (counter enabled). There are four transitions. ARM goes from IDLE to ARMED when the mode becomes trigger. FIRE goes from ARMED, or from IDLE when the mode is already trigger, to RUN on a synchronized rising edge. DISARM goes from ARMED to IDLE, and STOP goes from RUN to IDLE; both happen when the mode leaves trigger. The slave counter enable is high exactly in RUN.

Top module: `tim_trig_link`

## Requirements
- R1: The trigger output source is chosen by `mst_trgo_sel`, and the chosen value appears on `mst_trgo` one master clock later. Code 0 selects the reset event, 1 the counter enable, 2 the update pulse, and 3, 4, 5, 6 select compare references 1, 2, 3, 4 (`mst_ocref` bits 0 to 3). Code 7 holds the output low.
- R2: With code 2 selected, each single-cycle update pulse gives exactly one single-cycle pulse on `mst_trgo`.
- R3: A slave's 3-bit select field (`slv_tsel` bits 3s+2 to 3s for slave s) chooses its trigger. Code 0 is the master trigger output, and code k (1 to 7) is `itr_in[k]`.
- R4: In trigger mode (mode code 01), a rising edge on the selected input that is set up before slave clock edge n raises that slave's `slv_cen` at slave clock edge n+2, three slave edges in all.
- R5: An armed slave does not start without a rising edge. Edges on inputs it has not selected have no effect, and a selected input that is already high when the slave is armed does not start it.
- R6: Once started, `slv_cen` stays high while the mode stays 01. Later falling or rising edges of the trigger are ignored.
- R7: Any mode other than 01 (00 off, 10 and 11 reserved) drives `slv_cen` low at the next slave clock edge and prevents a start.
- R8: After reset, `mst_trgo` and every `slv_cen` are low.
- R9: Several slaves may select the same trigger. All armed slaves that share it start on the same slave clock edge, and a slave that is not armed stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master clock |
| mst_rst_n | input | 1 | Master async reset, active low |
| mst_trgo_sel | input | 3 | Trigger output source select |
| mst_evt_reset | input | 1 | Master counter-reset event |
| mst_evt_enable | input | 1 | Master counter-enable level |
| mst_evt_update | input | 1 | Master update (overflow) pulse |
| mst_ocref | input | 4 | Master compare reference levels 1 to 4 |
| mst_trgo | output | 1 | Registered master trigger output |
| slv_clk | input | 1 | Slave clock |
| slv_rst_n | input | 1 | Slave async reset, active low |
| itr_in | input | 7 | Trigger inputs 1 to 7 (index 1 upward) |
| slv_tsel | input | 3*NUM_SLV | Per-slave trigger select |
| slv_mode | input | 2*NUM_SLV | Per-slave mode (01 trigger) |
| slv_cen | output | NUM_SLV | Per-slave counter enable |

## Verification
The hardest case to reach is the start path through trigger input 0. There the edge comes from the master clock domain, so its arrival relative to the slave clock is not fixed, and a start that fires on the wrong edge would look the same. The stimulus arms two slaves on that input and pulses one master update. It then compares the two enables on every slave cycle, so any cycle offset between them is caught. It checks the exact three-edge latency only on inputs driven in step with the slave clock. The level-high arming case is reached by leaving a selected input high after a previous test and arming the slave only after that.

// File: rtl/tim_link_pkg.sv
package tim_link_pkg;

    typedef enum logic [2:0] {
        TRGO_RST  = 3'd0,
        TRGO_EN   = 3'd1,
        TRGO_UPD  = 3'd2,
        TRGO_OC1  = 3'd3,
        TRGO_OC2  = 3'd4,
        TRGO_OC3  = 3'd5,
        TRGO_OC4  = 3'd6,
        TRGO_NONE = 3'd7
    } trgo_src_e;

    typedef enum logic [1:0] {
        SMODE_OFF  = 2'b00,
        SMODE_TRIG = 2'b01,
        SMODE_RSV2 = 2'b10,
        SMODE_RSV3 = 2'b11
    } smode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } slv_state_e;

endpackage

// File: rtl/trgo_select.sv
module trgo_select
    import tim_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       evt_rst,
    input  logic       evt_en,
    input  logic       evt_upd,
    input  logic [3:0] ocref,
    output logic       trgo
);

    logic trgo_nxt;

    always_comb begin
        unique case (trgo_src_e'(sel))
            TRGO_RST:  trgo_nxt = evt_rst;
            TRGO_EN:   trgo_nxt = evt_en;
            TRGO_UPD:  trgo_nxt = evt_upd;
            TRGO_OC1:  trgo_nxt = ocref[0];
            TRGO_OC2:  trgo_nxt = ocref[1];
            TRGO_OC3:  trgo_nxt = ocref[2];
            TRGO_OC4:  trgo_nxt = ocref[3];
            TRGO_NONE: trgo_nxt = 1'b0;
        endcase
    end

    // registered so the crossing into slave clocks sees a glitch-free level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trgo <= 1'b0;
        else        trgo <= trgo_nxt;
    end

    // R2: an update pulse with the update source selected shows on the output
    a_r2_update_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == TRGO_UPD && evt_upd) |=> trgo);

    // R1: the unused code keeps the output low
    a_r1_none_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == TRGO_NONE) |=> !trgo);

endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end

endmodule

// File: rtl/slave_trig_fsm.sv
module slave_trig_fsm
    import tim_link_pkg::*;
#(
    parameter int NUM_ITR = 8,
    localparam int TSEL_W = $clog2(NUM_ITR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [TSEL_W-1:0]  tsel,
    input  logic [NUM_ITR-1:0] itr_sync,
    output logic               cen
);

    slv_state_e state_q, state_d;
    logic       sel_lvl;
    logic       sel_prev;
    logic       edge_hit;
    logic       trig_mode;

    assign sel_lvl   = itr_sync[tsel];
    assign edge_hit  = sel_lvl && !sel_prev;
    assign trig_mode = (smode_e'(mode) == SMODE_TRIG);

    // edge register runs in every state so a level high at arming is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_mode) state_d = edge_hit ? ST_RUN : ST_ARMED;  // FIRE / ARM
            end
            ST_ARMED: begin
                if (!trig_mode)    state_d = ST_IDLE;                   // DISARM
                else if (edge_hit) state_d = ST_RUN;                    // FIRE
            end
            ST_RUN: begin
                if (!trig_mode) state_d = ST_IDLE;                      // STOP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cen = (state_q == ST_RUN);
    end

    // R7: leaving trigger mode stops the counter at the next edge
    a_r7_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_mode |=> !cen);

    // R6: a running slave stays running while the mode holds
    a_r6_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && trig_mode) |=> cen);

    // R4: a start is always caused by a detected rising edge
    a_r4_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cen) |-> $past(edge_hit && trig_mode));

    // R5: no edge, no start
    a_r5_no_edge_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen && !edge_hit) |=> !cen);

endmodule

// File: rtl/tim_trig_link.sv
module tim_trig_link
    import tim_link_pkg::*;
#(
    parameter int NUM_SLV = 2,
    parameter int NUM_ITR = 8,
    localparam int TSEL_W = $clog2(NUM_ITR)
) (
    input  logic                      mst_clk,
    input  logic                      mst_rst_n,
    input  logic [2:0]                mst_trgo_sel,
    input  logic                      mst_evt_reset,
    input  logic                      mst_evt_enable,
    input  logic                      mst_evt_update,
    input  logic [3:0]                mst_ocref,
    output logic                      mst_trgo,
    input  logic                      slv_clk,
    input  logic                      slv_rst_n,
    input  logic [NUM_ITR-1:1]        itr_in,
    input  logic [NUM_SLV*TSEL_W-1:0] slv_tsel,
    input  logic [NUM_SLV*2-1:0]      slv_mode,
    output logic [NUM_SLV-1:0]        slv_cen
);

    logic [NUM_ITR-1:0] itr_all;
    logic [NUM_ITR-1:0] itr_sync;

    trgo_select u_trgo (
        .clk     (mst_clk),
        .rst_n   (mst_rst_n),
        .sel     (mst_trgo_sel),
        .evt_rst (mst_evt_reset),
        .evt_en  (mst_evt_enable),
        .evt_upd (mst_evt_update),
        .ocref   (mst_ocref),
        .trgo    (mst_trgo)
    );

    // input 0 of every slave is the master trigger output
    assign itr_all = {itr_in, mst_trgo};

    trig_sync #(.WIDTH(NUM_ITR)) u_sync (
        .clk   (slv_clk),
        .rst_n (slv_rst_n),
        .d     (itr_all),
        .q     (itr_sync)
    );

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        slave_trig_fsm #(.NUM_ITR(NUM_ITR)) u_fsm (
            .clk      (slv_clk),
            .rst_n    (slv_rst_n),
            .mode     (slv_mode[s*2 +: 2]),
            .tsel     (slv_tsel[s*TSEL_W +: TSEL_W]),
            .itr_sync (itr_sync),
            .cen      (slv_cen[s])
        );
    end

endmodule

// File: tb/tim_trig_link_bench.sv
module tim_trig_link_bench;

    localparam int NS = 2;

    logic       mst_clk = 1'b0;
    logic       slv_clk = 1'b0;
    logic       mst_rst_n = 1'b0;
    logic       slv_rst_n = 1'b0;
    logic [2:0] mst_trgo_sel = 3'd7;
    logic       mst_evt_reset = 1'b0;
    logic       mst_evt_enable = 1'b0;
    logic       mst_evt_update = 1'b0;
    logic [3:0] mst_ocref = 4'd0;
    logic       mst_trgo;
    logic [7:1] itr_in = '0;
    logic [NS*3-1:0] slv_tsel = '0;
    logic [NS*2-1:0] slv_mode = '0;
    logic [NS-1:0]   slv_cen;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 mst_clk = ~mst_clk;
    always #3 slv_clk = ~slv_clk;

    tim_trig_link #(.NUM_SLV(NS), .NUM_ITR(8)) u_tim_trig_link (
        .mst_clk(mst_clk), .mst_rst_n(mst_rst_n), .mst_trgo_sel(mst_trgo_sel),
        .mst_evt_reset(mst_evt_reset), .mst_evt_enable(mst_evt_enable),
        .mst_evt_update(mst_evt_update), .mst_ocref(mst_ocref), .mst_trgo(mst_trgo),
        .slv_clk(slv_clk), .slv_rst_n(slv_rst_n), .itr_in(itr_in),
        .slv_tsel(slv_tsel), .slv_mode(slv_mode), .slv_cen(slv_cen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sclk(input int n);
        for (int i = 0; i < n; i++) @(negedge slv_clk);
    endtask

    task automatic set_slv(input int s, input logic [2:0] t, input logic [1:0] m);
        slv_tsel[s*3 +: 3] = t;
        slv_mode[s*2 +: 2] = m;
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge mst_clk);
        mst_rst_n = 1'b1;
        @(negedge slv_clk);
        slv_rst_n = 1'b1;
        sclk(2);
        // R8: reset state
        chk(mst_trgo == 1'b0, "R8 trgo", int'(mst_trgo), 0);
        chk(slv_cen == '0, "R8 cen", int'(slv_cen), 0);

        // R1: exhaustive source sweep; pattern bit k is the source of code k
        for (int sel = 0; sel < 8; sel++) begin
            for (int pat = 0; pat < 128; pat++) begin
                @(negedge mst_clk);
                mst_trgo_sel   = 3'(sel);
                mst_evt_reset  = pat[0];
                mst_evt_enable = pat[1];
                mst_evt_update = pat[2];
                mst_ocref      = 4'(pat >> 3);
                @(negedge mst_clk);
                chk(mst_trgo == ((sel < 7) ? pat[sel] : 1'b0), "R1 trgo select",
                    int'(mst_trgo), (sel < 7) ? int'(pat[sel]) : 0);
            end
        end
        @(negedge mst_clk);
        mst_trgo_sel = 3'd7;
        {mst_evt_reset, mst_evt_enable, mst_evt_update, mst_ocref} = '0;

        // R3 R4 R5 R6 R7: each slave, each external input
        for (int s = 0; s < NS; s++) begin
            for (int t = 1; t < 8; t++) begin
                automatic int oth = (t == 7) ? 1 : t + 1;
                @(negedge slv_clk);
                itr_in = '0;
                set_slv(0, 3'd0, 2'b00);
                set_slv(1, 3'd0, 2'b00);
                sclk(4);
                set_slv(s, 3'(t), 2'b01);
                sclk(4);
                chk(slv_cen[s] == 1'b0, "R5 armed idle", int'(slv_cen[s]), 0);
                itr_in[oth] = 1'b1;
                sclk(5);
                chk(slv_cen[s] == 1'b0, "R5 unselected edge", int'(slv_cen[s]), 0);
                itr_in[oth] = 1'b0;
                sclk(3);
                itr_in[t] = 1'b1;
                sclk(1);
                chk(slv_cen[s] == 1'b0, "R4 latency edge1", int'(slv_cen[s]), 0);
                sclk(1);
                chk(slv_cen[s] == 1'b0, "R4 latency edge2", int'(slv_cen[s]), 0);
                sclk(1);
                chk(slv_cen[s] == 1'b1, "R3 R4 start edge3", int'(slv_cen[s]), 1);
                chk(slv_cen[1-s] == 1'b0, "R9 unarmed slave", int'(slv_cen[1-s]), 0);
                itr_in[t] = 1'b0;
                sclk(4);
                itr_in[t] = 1'b1;
                sclk(4);
                chk(slv_cen[s] == 1'b1, "R6 hold", int'(slv_cen[s]), 1);
                set_slv(s, 3'(t), 2'b00);
                sclk(1);
                chk(slv_cen[s] == 1'b0, "R7 stop", int'(slv_cen[s]), 0);
                // input still high: arming now must not start
                sclk(3);
                set_slv(s, 3'(t), 2'b01);
                sclk(6);
                chk(slv_cen[s] == 1'b0, "R5 level at arm", int'(slv_cen[s]), 0);
                set_slv(s, 3'(t), 2'b00);
            end
        end

        // R7: reserved modes never start
        for (int m = 2; m < 4; m++) begin
            @(negedge slv_clk);
            itr_in = '0;
            set_slv(0, 3'd3, 2'(m));
            sclk(4);
            itr_in[3] = 1'b1;
            sclk(6);
            chk(slv_cen[0] == 1'b0, "R7 reserved mode", int'(slv_cen[0]), 0);
        end
        @(negedge slv_clk);
        itr_in = '0;
        set_slv(0, 3'd0, 2'b00);
        sclk(4);

        // R2 R3 R9: both slaves on the master output, started by one update
        @(negedge mst_clk);
        mst_trgo_sel = 3'd2;
        set_slv(0, 3'd0, 2'b01);
        set_slv(1, 3'd0, 2'b01);
        repeat (3) @(negedge mst_clk);
        chk(slv_cen == '0, "R5 wait for master", int'(slv_cen), 0);
        mst_evt_update = 1'b1;
        @(negedge mst_clk);
        mst_evt_update = 1'b0;
        chk(mst_trgo == 1'b1, "R2 pulse high", int'(mst_trgo), 1);
        @(negedge mst_clk);
        chk(mst_trgo == 1'b0, "R2 pulse one cycle", int'(mst_trgo), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge slv_clk);
            chk(slv_cen[0] == slv_cen[1], "R9 same start cycle",
                int'(slv_cen[1]), int'(slv_cen[0]));
        end
        chk(slv_cen == 2'b11, "R3 R9 master started both", int'(slv_cen), 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule